// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits after a page-table walker. It receives one leaf page-table entry, the kind of access (load, store or instruction fetch), the processor's problem-state flag and a separate three-bit authority-mask permission set. From these it works out the read, write and execute rights to grant and decides whether the access faults. It reports the result one cycle after it accepts the request.

When the access is allowed, the block builds an updated copy of the entry with the reference bit set. On a store it also sets the change bit. If the updated entry differs from the original, the block issues a write request to memory, holds it until the memory acknowledges it, and only then reports success. When a load or fetch is allowed, write permission is left out of the granted set, so a later store must come back through this path to set the change bit.

When the access faults, the block records the cause. A data-side fault latches the cause (with a store flag on stores) and the faulting address. An instruction-side fault latches the cause as a separate error code.

Top module: `page_perm_checker`

## Requirements
- R1: The access kind is encoded as 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load. Permission vectors (the authority mask and the granted set) put read in bit 2, write in bit 1 and execute in bit 0. The entry fields are: reference bit 8, change bit 7, attribute field bits 5:4, privileged bit 3, read-only authority bit 2, read/write authority bit 1, execute authority bit 0.
- R2: A fetch from a page whose attribute field equals 2'b10 (non-idempotent I/O) faults with cause 3'b010 (guarded/no-execute), whatever the authority bits say.
- R3: If the privileged bit is set and problem state is 1, nothing is granted. Any access then faults with cause bit 0 (protection).
- R4: In problem state, or when the page is privileged, rights come only from the entry: read = bit 2 OR bit 1, write = bit 1, execute = bit 0. The authority mask is ignored.
- R5: For a privileged-state access (problem state 0) to a non-privileged page, the rights from the entry are ANDed with the authority mask.
- R6: If the right needed by the access kind is missing, the access faults with cause 3'b001 and the granted set is reported as 3'b000.
- R7: On a permitted access the updated entry has the reference bit set, and on a store the change bit as well. For a load or fetch, the reported granted set has its write bit cleared.
- R8: A write request is raised only when the updated entry differs from the original. Address and data stay stable until the acknowledge, and success is reported in the cycle after the acknowledge. With no change, success is reported in the cycle after the request.
- R9: On a data-side fault, the data cause register takes the cause, with bit 2 (store) set for stores, and the fault address register takes the request address. On a fetch fault only the instruction error code register takes the cause.
- R10: A fault is reported in the cycle after the request and never comes with a write request. The write request and the response strobe are never high together.
- R11: The ready output is low while a write-back is outstanding, and requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Check request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | Access kind (R1) |
| req_problem | input | 1 | Problem-state flag |
| req_mask | input | 3 | Authority-mask permission set |
| req_pte | input | PTE_W | Leaf entry to check |
| req_pte_addr | input | ADDR_W | Memory address of the entry |
| req_addr | input | ADDR_W | Effective address of the access |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a fault |
| resp_perm | output | 3 | Granted permission set |
| wb_req | output | 1 | Entry write-back request |
| wb_ack | input | 1 | Write-back acknowledge |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | PTE_W | Updated entry |
| dfault_cause | output | 3 | Latched data-side fault cause |
| dfault_addr | output | ADDR_W | Latched data-side fault address |
| ifault_code | output | 3 | Latched instruction-side error code |

## Verification
A wrong stored access kind would show in the first response after a load hit as a granted write bit, or as a missing store flag in the data cause register. A stuck write-back state would show as ready staying low, or as a response that never follows an acknowledge, within one cycle of the acknowledge. A wrong decision about when to write back shows up as a write request where none belongs, or as success arriving one cycle early, in the cycle right after the request. Each fault path is checked by reading the latched cause registers, including the registers that must stay untouched.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_W   = 3;
  localparam int CAUSE_W  = 3;
  localparam int PERM_RD  = 2;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 0;

  localparam int BIT_REF  = 8;
  localparam int BIT_CHG  = 7;
  localparam int ATT_HI   = 5;
  localparam int ATT_LO   = 4;
  localparam int BIT_PRIV = 3;
  localparam int BIT_AR   = 2;
  localparam int BIT_ARW  = 1;
  localparam int BIT_AX   = 0;

  localparam logic [1:0] ATT_NI_IO = 2'b10;

  localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 3'b001;
  localparam logic [CAUSE_W-1:0] CAUSE_GUARD = 3'b010;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 3'b100;

  typedef enum logic {ST_IDLE = 1'b0, ST_WB = 1'b1} chk_state_e;
endpackage

// File: rtl/pchk_perm_eval.sv
module pchk_perm_eval
  import pchk_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic [1:0]         kind,
  input  logic               problem,
  input  logic [PERM_W-1:0]  mask,
  output logic [PERM_W-1:0]  grant,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic [PERM_W-1:0] eaa_perm;
  logic [PERM_W-1:0] raw_perm;
  logic [PERM_W-1:0] need;
  logic              io_fetch;
  logic              prot_fault;

  always_comb begin
    eaa_perm[PERM_RD] = pte[BIT_AR] | pte[BIT_ARW];
    eaa_perm[PERM_WR] = pte[BIT_ARW];
    eaa_perm[PERM_EX] = pte[BIT_AX];

    io_fetch = (pte[ATT_HI:ATT_LO] == ATT_NI_IO) && (kind == ACC_FETCH);

    if (pte[BIT_PRIV] && problem)
      raw_perm = '0;
    else if (problem || pte[BIT_PRIV])
      raw_perm = eaa_perm;
    else
      raw_perm = eaa_perm & mask;

    case (kind)
      ACC_STORE: need = PERM_W'(1) << PERM_WR;
      ACC_FETCH: need = PERM_W'(1) << PERM_EX;
      default:   need = PERM_W'(1) << PERM_RD;
    endcase

    prot_fault = |(need & ~raw_perm);
    fault      = io_fetch | prot_fault;
    cause      = io_fetch ? CAUSE_GUARD : (prot_fault ? CAUSE_PROT : '0);

    if (fault)
      grant = '0;
    else if (kind == ACC_STORE)
      grant = raw_perm;
    else
      grant = raw_perm & ~(PERM_W'(1) << PERM_WR);
  end
endmodule

// File: rtl/pchk_rc_update.sv
module pchk_rc_update
  import pchk_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_store,
  output logic [PTE_W-1:0] pte_new,
  output logic             changed
);
  always_comb begin
    pte_new = pte;
    pte_new[BIT_REF] = 1'b1;
    if (is_store)
      pte_new[BIT_CHG] = 1'b1;
    changed = |(pte_new ^ pte);
  end
endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker
  import pchk_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic               req_problem,
  input  logic [2:0]         req_mask,
  input  logic [PTE_W-1:0]   req_pte,
  input  logic [ADDR_W-1:0]  req_pte_addr,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [2:0]         resp_perm,
  output logic               wb_req,
  input  logic               wb_ack,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [PTE_W-1:0]   wb_data,
  output logic [2:0]         dfault_cause,
  output logic [ADDR_W-1:0]  dfault_addr,
  output logic [2:0]         ifault_code
);
  logic [PERM_W-1:0]  grant;
  logic               fault;
  logic [CAUSE_W-1:0] cause;
  logic [PTE_W-1:0]   pte_new;
  logic               changed;

  pchk_perm_eval #(.PTE_W(PTE_W)) u_eval (
    .pte     (req_pte),
    .kind    (req_kind),
    .problem (req_problem),
    .mask    (req_mask),
    .grant   (grant),
    .fault   (fault),
    .cause   (cause)
  );

  pchk_rc_update #(.PTE_W(PTE_W)) u_rc (
    .pte      (req_pte),
    .is_store (req_kind == ACC_STORE),
    .pte_new  (pte_new),
    .changed  (changed)
  );

  chk_state_e         state_q, state_d;
  logic               rv_q, rv_d;
  logic               rf_q, rf_d;
  logic [PERM_W-1:0]  rp_q, rp_d;
  logic               wbr_q, wbr_d;
  logic [ADDR_W-1:0]  wba_q, wba_d;
  logic [PTE_W-1:0]   wbd_q, wbd_d;
  logic [1:0]         kind_q, kind_d;
  logic [CAUSE_W-1:0] dc_q, dc_d;
  logic [ADDR_W-1:0]  da_q, da_d;
  logic [CAUSE_W-1:0] ic_q, ic_d;
  logic               accept;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    rv_d    = 1'b0;
    rf_d    = rf_q;
    rp_d    = rp_q;
    wbr_d   = wbr_q;
    wba_d   = wba_q;
    wbd_d   = wbd_q;
    kind_d  = kind_q;
    dc_d    = dc_q;
    da_d    = da_q;
    ic_d    = ic_q;
    if (accept) begin
      kind_d = req_kind;
      rp_d   = grant;
      rf_d   = fault;
      if (fault) begin
        rv_d = 1'b1;
        if (req_kind == ACC_FETCH) begin
          ic_d = cause;
        end else begin
          dc_d = cause | ((req_kind == ACC_STORE) ? CAUSE_STORE : '0);
          da_d = req_addr;
        end
      end else if (changed) begin
        state_d = ST_WB;
        wbr_d   = 1'b1;
        wba_d   = req_pte_addr;
        wbd_d   = pte_new;
      end else begin
        rv_d = 1'b1;
      end
    end else if (state_q == ST_WB && wb_ack) begin
      state_d = ST_IDLE;
      wbr_d   = 1'b0;
      rv_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
      rf_q    <= 1'b0;
      rp_q    <= '0;
      wbr_q   <= 1'b0;
      wba_q   <= '0;
      wbd_q   <= '0;
      kind_q  <= ACC_LOAD;
      dc_q    <= '0;
      da_q    <= '0;
      ic_q    <= '0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
      rf_q    <= rf_d;
      rp_q    <= rp_d;
      wbr_q   <= wbr_d;
      wba_q   <= wba_d;
      wbd_q   <= wbd_d;
      kind_q  <= kind_d;
      dc_q    <= dc_d;
      da_q    <= da_d;
      ic_q    <= ic_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = rv_q;
  assign resp_fault   = rf_q;
  assign resp_perm    = rp_q;
  assign wb_req       = wbr_q;
  assign wb_addr      = wba_q;
  assign wb_data      = wbd_q;
  assign dfault_cause = dc_q;
  assign dfault_addr  = da_q;
  assign ifault_code  = ic_q;

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_data));

  p_ack_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> resp_valid && !resp_fault && !wb_req);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req && resp_valid));

  p_ref_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> wb_data[BIT_REF]);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !req_ready);

  p_no_wr_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault && (kind_q != ACC_STORE) |-> !resp_perm[PERM_WR]);

  p_fault_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_perm == '0);
endmodule

// File: tb/page_perm_checker_test.sv
`timescale 1ns/1ps
module page_perm_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_problem = 1'b0;
  logic [2:0]  req_mask = 3'd0;
  logic [63:0] req_pte = '0;
  logic [63:0] req_pte_addr = '0;
  logic [63:0] req_addr = '0;
  logic        resp_valid, resp_fault;
  logic [2:0]  resp_perm;
  logic        wb_req;
  logic        wb_ack = 1'b0;
  logic [63:0] wb_addr, wb_data;
  logic [2:0]  dfault_cause, ifault_code;
  logic [63:0] dfault_addr;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  page_perm_checker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_problem(req_problem), .req_mask(req_mask),
    .req_pte(req_pte), .req_pte_addr(req_pte_addr), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_perm(resp_perm),
    .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_data(wb_data),
    .dfault_cause(dfault_cause), .dfault_addr(dfault_addr), .ifault_code(ifault_code)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, accepted at posedge, outputs checked at next negedge
  task automatic issue(input logic [1:0] k, input logic ps, input logic [2:0] m,
                       input logic [63:0] pte, input logic [63:0] pa, input logic [63:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_problem = ps; req_mask = m;
    req_pte = pte; req_pte_addr = pa; req_addr = ea;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [2:0] perm);
    chk({tag, " resp_valid"}, resp_valid, 1);
    chk({tag, " resp_fault"}, resp_fault, 0);
    chk({tag, " resp_perm"}, resp_perm, perm);
    chk({tag, " no wb_req"}, wb_req, 0);
  endtask

  task automatic expect_wb(input string tag, input logic [63:0] pa, input logic [63:0] d,
                           input logic [2:0] perm);
    chk({tag, " wb_req"}, wb_req, 1);
    chk({tag, " no resp"}, resp_valid, 0);
    chk({tag, " wb_addr"}, wb_addr, pa);
    chk({tag, " wb_data"}, wb_data, d);
    @(negedge clk);
    chk({tag, " wb held"}, wb_req, 1);
    chk({tag, " wb data stable"}, wb_data, d);
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    expect_ok({tag, " after ack"}, perm);
  endtask

  task automatic t_reset;
    chk("R10 reset resp_valid", resp_valid, 0);
    chk("R11 reset ready", req_ready, 1);
    chk("R8 reset wb_req", wb_req, 0);
    chk("R9 reset dfault_cause", dfault_cause, 0);
    chk("R9 reset ifault_code", ifault_code, 0);
  endtask

  task automatic t_load_first;   // R4 R7 R8
    issue(2'd0, 1'b1, 3'b000, 64'h002, 64'h1000, 64'hA0);
    expect_wb("R7 load sets ref", 64'h1000, 64'h102, 3'b100);
  endtask

  task automatic t_load_nochange; // R8
    issue(2'd0, 1'b1, 3'b000, 64'h102, 64'h1008, 64'hA8);
    expect_ok("R8 load ref already set", 3'b100);
  endtask

  task automatic t_rsvd_kind;    // R1
    issue(2'd3, 1'b1, 3'b000, 64'h102, 64'h1008, 64'hA8);
    expect_ok("R1 kind 3 as load", 3'b100);
  endtask

  task automatic t_store;        // R7 R8
    issue(2'd1, 1'b1, 3'b000, 64'h102, 64'h2000, 64'hB0);
    expect_wb("R7 store sets change", 64'h2000, 64'h182, 3'b110);
    issue(2'd1, 1'b1, 3'b000, 64'h182, 64'h2000, 64'hB0);
    expect_ok("R8 store no change", 3'b110);
  endtask

  task automatic t_priv_problem; // R3 R9
    issue(2'd0, 1'b1, 3'b111, 64'h10E, 64'h3000, 64'hC0DE);
    chk("R3 fault", resp_fault, 1);
    chk("R3 resp_valid", resp_valid, 1);
    chk("R10 no wb on fault", wb_req, 0);
    chk("R3 perm none", resp_perm, 0);
    chk("R9 load cause", dfault_cause, 3'b001);
    chk("R9 fault addr", dfault_addr, 64'hC0DE);
  endtask

  task automatic t_mask;         // R5 R9
    issue(2'd0, 1'b0, 3'b100, 64'h107, 64'h4000, 64'hD0);
    expect_ok("R5 mask limits", 3'b100);
    issue(2'd1, 1'b0, 3'b100, 64'h107, 64'h4000, 64'hD8);
    chk("R5 store masked fault", resp_fault, 1);
    chk("R9 store flag", dfault_cause, 3'b101);
    chk("R9 store addr", dfault_addr, 64'hD8);
  endtask

  task automatic t_priv_page;    // R4
    issue(2'd2, 1'b0, 3'b000, 64'h10D, 64'h5000, 64'hE0);
    expect_ok("R4 mask ignored on privileged page", 3'b101);
  endtask

  task automatic t_io_fetch;     // R2 R9
    issue(2'd2, 1'b1, 3'b000, 64'h121, 64'h6000, 64'hF0);
    chk("R2 io fetch fault", resp_fault, 1);
    chk("R2 guard code", ifault_code, 3'b010);
    chk("R9 data cause untouched", dfault_cause, 3'b101);
    chk("R9 data addr untouched", dfault_addr, 64'hD8);
  endtask

  task automatic t_noexec;       // R6
    issue(2'd2, 1'b1, 3'b000, 64'h104, 64'h7000, 64'hF8);
    chk("R6 fetch no x fault", resp_fault, 1);
    chk("R6 perm none", resp_perm, 0);
    chk("R6 prot code", ifault_code, 3'b001);
  endtask

  task automatic t_busy;         // R11
    issue(2'd0, 1'b1, 3'b000, 64'h004, 64'h8000, 64'h10);
    chk("R11 ready low", req_ready, 0);
    req_valid = 1'b1; req_kind = 2'd1; req_pte = 64'h10E; req_addr = 64'h99;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 ignored: wb still", wb_req, 1);
    chk("R11 ignored: no resp", resp_valid, 0);
    chk("R11 ignored: data", wb_data, 64'h104);
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    expect_ok("R11 single response", 3'b100);
    @(negedge clk);
    chk("R11 no extra resp", resp_valid, 0);
    chk("R11 ignored: dcause", dfault_cause, 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_first();
    t_load_nochange();
    t_rsvd_kind();
    t_store();
    t_priv_problem();
    t_mask();
    t_priv_page();
    t_io_fetch();
    t_noexec();
    t_busy();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule